// File: doc/BRIEF.md
# Prioritised Interrupt Router with Claim and Completion

This block gathers level-sensitive interrupt requests from a parameterised set of sources and steers them to a parameterised set of processor contexts. Each source has a small priority value. Each context has three things: its own mask of enabled sources, a priority threshold, and a claim/completion register. Each context drives one interrupt line. Software running on a context reads the claim register to take ownership of the most urgent request. It services the device and then writes the same source number back to say it is done.

Each source has a gateway that turns the level request into a pending flag. The gateway holds the source off from the moment the source is claimed until it is completed. This means a device that keeps its request asserted during service does not raise a second interrupt. Claiming clears the pending flag, so at most one context ever receives a given request. Access goes through a plain synchronous register port: reads return data one cycle after the strobe, and writes take effect at the clock edge.

Top module: `irq_hub`

## Requirements
- R1: Bit k of `src_req` is the request of source ID k+1. ID 0 is reserved. The priority of source ID n is the register at byte address 4·n. It holds PRIO_W bits and the upper bits read as 0. Addresses for ID 0 and for IDs above N_SRC read 0 and ignore writes.
- R2: The enable word w of context c is at byte address 0x2000 + 0x80·c + 4·w. Bit b of that word enables source ID 32·w + b. The bit for ID 0, and bits for IDs above N_SRC, read 0.
- R3: The threshold of context c is at 0x200000 + 0x1000·c. `ctx_irq[c]` is high exactly when an enabled pending source of context c has a priority strictly greater than that threshold. The output is registered, so it follows a state change one cycle later.
- R4: A read of the claim register at 0x200004 + 0x1000·c returns, in the cycle after the strobe, the ID of the enabled pending source with the highest priority. Among sources of equal priority, the lowest ID is returned.
- R5: A claim clears that source's pending flag and puts the source in service. While in service, its request is not latched again, and no context can claim it.
- R6: Writing an ID to any context's claim register ends service of that source. A level request still present is then latched again. A completion for a source that is not in service, or for an ID outside 1..N_SRC, changes nothing.
- R7: A claim read with no eligible source returns 0 and alters no pending or in-service state.
- R8: Any other address, including non-existent contexts and unused offsets, reads 0 and ignores writes.
- R9: Synchronous reset clears all priorities, enables, thresholds, pending flags, in-service flags, read data and interrupt outputs.
- R10: A source with priority 0 never raises an interrupt and is never returned by a claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N_SRC | Level requests; bit k is source ID k+1 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (claim side effects apply) |
| reg_addr | input | ADDR_W | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd`, 0 otherwise |
| ctx_irq | output | N_CTX | Registered interrupt line per context |

## Verification
Suppose a gateway's pending or in-service flag goes wrong. At the ports, this shows up as a claim returning the wrong ID, or returning a repeat ID while the source is still in service. It can also show up as an interrupt line that stays high after its only source was claimed. The claim data appears one cycle after the strobe, and the interrupt line shows the error one cycle after the faulty state. A wrong priority, enable or threshold bit changes the winner of a claim or the level of `ctx_irq` within two cycles. For that reason, each source is swept one at a time through request, claim and completion, and ties and threshold boundaries are then checked with literal expected IDs.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam logic [31:0] PRIO_LIMIT = 32'h0000_1000;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam int          EN_SHIFT   = 7;
  localparam int          CTX_SHIFT  = 12;

  typedef enum logic [1:0] {
    RG_NONE,
    RG_PRIO,
    RG_EN,
    RG_CTX
  } region_e;
endpackage

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic take,
  input  logic done,
  output logic pending,
  output logic in_serv
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      in_serv <= 1'b0;
    end else if (take) begin
      pending <= 1'b0;
      in_serv <= 1'b1;
    end else begin
      if (done && in_serv) in_serv <= 1'b0;
      if (req && !in_serv) pending <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_SRC  = 31,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC-1:0]        elig,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  output logic [ID_W-1:0]         best_id,
  output logic [PRIO_W-1:0]       best_prio
);
  // strict greater-than keeps the lowest ID on ties and skips priority 0
  always_comb begin
    best_id   = '0;
    best_prio = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && prio_flat[i*PRIO_W +: PRIO_W] > best_prio) begin
        best_prio = prio_flat[i*PRIO_W +: PRIO_W];
        best_id   = ID_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int N_SRC  = 31,
  parameter int N_CTX  = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_req,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [N_CTX-1:0]  ctx_irq
);
  localparam int ID_W     = $clog2(N_SRC + 1);
  localparam int EN_WORDS = (N_SRC + 32) / 32;
  localparam int CTX_W    = (N_CTX > 1) ? $clog2(N_CTX) : 1;

  logic [PRIO_W-1:0]       prio_q [N_SRC];
  logic [N_SRC-1:0]        en_q   [N_CTX];
  logic [PRIO_W-1:0]       thr_q  [N_CTX];
  logic [N_SRC-1:0]        pend, insv, take_vec, done_vec;
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic [ID_W-1:0]         best_id   [N_CTX];
  logic [PRIO_W-1:0]       best_prio [N_CTX];

  region_e           rg;
  logic [CTX_W-1:0]  dctx;
  logic [ID_W-1:0]   dsrc;
  logic [4:0]        dword;
  logic              dclaim;
  logic              claim_hit, done_hit;
  logic [31:0]       rd_next;

  // address decode
  always_comb begin
    logic [31:0] a, rel;
    a      = 32'(reg_addr);
    rel    = '0;
    rg     = RG_NONE;
    dctx   = '0;
    dsrc   = '0;
    dword  = '0;
    dclaim = 1'b0;
    if (a[1:0] == 2'b00) begin
      if (a >= CTX_BASE) begin
        rel = a - CTX_BASE;
        if ((rel >> CTX_SHIFT) < 32'(N_CTX) &&
            (rel[11:0] == 12'h000 || rel[11:0] == 12'h004)) begin
          rg     = RG_CTX;
          dctx   = CTX_W'(rel >> CTX_SHIFT);
          dclaim = rel[2];
        end
      end else if (a >= EN_BASE) begin
        rel = a - EN_BASE;
        if ((rel >> EN_SHIFT) < 32'(N_CTX) && 32'(rel[6:2]) < 32'(EN_WORDS)) begin
          rg    = RG_EN;
          dctx  = CTX_W'(rel >> EN_SHIFT);
          dword = rel[6:2];
        end
      end else if (a < PRIO_LIMIT) begin
        if ((a >> 2) >= 32'd1 && (a >> 2) <= 32'(N_SRC)) begin
          rg   = RG_PRIO;
          dsrc = ID_W'(a >> 2);
        end
      end
    end
  end

  assign claim_hit = reg_rd && (rg == RG_CTX) && dclaim;
  assign done_hit  = reg_wr && (rg == RG_CTX) && dclaim;

  // one gateway per source
  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    assign prio_flat[k*PRIO_W +: PRIO_W] = prio_q[k];
    assign take_vec[k] = claim_hit && (best_id[dctx] == ID_W'(k + 1));
    assign done_vec[k] = done_hit && (reg_wdata == 32'(k + 1));
    irq_gate u_gate (
      .clk    (clk),
      .rst    (rst),
      .req    (src_req[k]),
      .take   (take_vec[k]),
      .done   (done_vec[k]),
      .pending(pend[k]),
      .in_serv(insv[k])
    );
  end

  // one selector per context
  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    irq_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_pick (
      .elig     (pend & en_q[c]),
      .prio_flat(prio_flat),
      .best_id  (best_id[c]),
      .best_prio(best_prio[c])
    );
  end

  // read mux
  always_comb begin
    rd_next = '0;
    unique case (rg)
      RG_PRIO: rd_next = 32'(prio_q[dsrc - ID_W'(1)]);
      RG_EN: begin
        for (int b = 0; b < 32; b++) begin
          if (int'(dword) * 32 + b >= 1 && int'(dword) * 32 + b <= N_SRC)
            rd_next[b] = en_q[dctx][int'(dword) * 32 + b - 1];
        end
      end
      RG_CTX:  rd_next = dclaim ? 32'(best_id[dctx]) : 32'(thr_q[dctx]);
      default: rd_next = '0;
    endcase
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_SRC; k++) prio_q[k] <= '0;
      for (int c = 0; c < N_CTX; c++) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end
    end else if (reg_wr) begin
      case (rg)
        RG_PRIO: prio_q[dsrc - ID_W'(1)] <= reg_wdata[PRIO_W-1:0];
        RG_EN: begin
          for (int b = 0; b < 32; b++) begin
            if (int'(dword) * 32 + b >= 1 && int'(dword) * 32 + b <= N_SRC)
              en_q[dctx][int'(dword) * 32 + b - 1] <= reg_wdata[b];
          end
        end
        RG_CTX: if (!dclaim) thr_q[dctx] <= reg_wdata[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      ctx_irq   <= '0;
    end else begin
      reg_rdata <= reg_rd ? rd_next : '0;
      for (int c = 0; c < N_CTX; c++) ctx_irq[c] <= best_prio[c] > thr_q[c];
    end
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int N_SRC = 31,
  parameter int N_CTX = 2,
  localparam int ID_W = $clog2(N_SRC + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [31:0]      reg_rdata,
  input logic [N_CTX-1:0] ctx_irq,
  input logic [N_SRC-1:0] pend,
  input logic [N_SRC-1:0] insv,
  input logic             claim_hit
);
  // R5: a claimed source can never be pending at the same time
  a_r5_pend_not_serv: assert property (@(posedge clk) disable iff (rst)
    (pend & insv) == '0);

  // R4: claim data is always a legal source ID or 0
  a_r4_id_range: assert property (@(posedge clk) disable iff (rst)
    $past(claim_hit) |-> reg_rdata <= 32'(N_SRC));

  // R5: a returned ID is in service afterwards
  a_r5_claim_marks: assert property (@(posedge clk) disable iff (rst)
    ($past(claim_hit) && reg_rdata != 0 && reg_rdata <= 32'(N_SRC))
      |-> insv[reg_rdata[ID_W-1:0] - ID_W'(1)]);

  // R3: an interrupt line needs something pending one cycle earlier
  a_r3_irq_source: assert property (@(posedge clk) disable iff (rst)
    (ctx_irq != '0) |-> $past(pend != '0));

  // R7: a claim with nothing pending returns 0 and keeps service state
  a_r7_idle_claim: assert property (@(posedge clk) disable iff (rst)
    (claim_hit && pend == '0) |=> (reg_rdata == 0 && $stable(insv)));

  // R9: reset clears outputs and gateway state
  a_r9_reset: assert property (@(posedge clk)
    rst |=> (ctx_irq == '0 && reg_rdata == 0 && pend == '0 && insv == '0));
endmodule

bind irq_hub irq_hub_chk #(.N_SRC(N_SRC), .N_CTX(N_CTX)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_rdata(reg_rdata),
  .ctx_irq  (ctx_irq),
  .pend     (pend),
  .insv     (insv),
  .claim_hit(claim_hit)
);

// File: tb/test_irq_hub.sv
`timescale 1ns/1ps
module test_irq_hub;
  localparam int NS = 31;
  localparam int NC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NS-1:0] src_req = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [23:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NC-1:0] ctx_irq;

  int nchk = 0, nerr = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  irq_hub #(.N_SRC(NS), .N_CTX(NC), .PRIO_W(3), .ADDR_W(24)) i_irq_hub (
    .clk(clk), .rst(rst), .src_req(src_req), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctx_irq(ctx_irq)
  );

  function automatic logic [31:0] a_prio(input int id); return 32'(4 * id); endfunction
  function automatic logic [31:0] a_en(input int c, input int w); return 32'h2000 + 32'(128 * c + 4 * w); endfunction
  function automatic logic [31:0] a_thr(input int c); return 32'h20_0000 + 32'(4096 * c); endfunction
  function automatic logic [31:0] a_clm(input int c); return 32'h20_0004 + 32'(4096 * c); endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a[23:0]; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a[23:0];
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 irq after reset", 32'(ctx_irq), 32'h0);
    rd(a_clm(0), v); check("R7 empty claim", v, 0);

    // R1 priority sweep, including reserved ID 0 and ID above range
    for (int id = 0; id <= NS + 1; id++) wr(a_prio(id), 32'hFFFF_FFF0 | 32'(id * 3 + 1));
    for (int id = 0; id <= NS + 1; id++) begin
      rd(a_prio(id), v);
      check($sformatf("R1 prio id %0d", id), v,
            (id >= 1 && id <= NS) ? 32'((id * 3 + 1) & 7) : 32'h0);
    end

    // R2 enables
    wr(a_en(0, 0), 32'hFFFF_FFFF);
    wr(a_en(1, 0), 32'h0000_00F0);
    rd(a_en(0, 0), v); check("R2 ctx0 enable word", v, 32'hFFFF_FFFE);
    rd(a_en(1, 0), v); check("R2 ctx1 enable word", v, 32'h0000_00F0);

    // R8 unimplemented addresses
    wr(32'h1000, 32'hFFFF_FFFF);
    wr(a_en(2, 0), 32'hFFFF_FFFF);
    wr(32'h20_0008, 32'hFFFF_FFFF);
    wr(a_thr(2), 32'h7);
    rd(32'h1000, v);      check("R8 gap read", v, 0);
    rd(a_en(2, 0), v);    check("R8 absent context enable", v, 0);
    rd(32'h20_0008, v);   check("R8 unused context offset", v, 0);
    rd(a_thr(2), v);      check("R8 absent context threshold", v, 0);
    rd(a_en(0, 1), v);    check("R8 enable word past range", v, 0);
    rd(a_thr(0), v);      check("R8 thresholds untouched", v, 0);

    // R3/R4/R5/R6 sweep over every source
    for (int s = 1; s <= NS; s++) wr(a_prio(s), 32'((s % 7) + 1));
    for (int s = 1; s <= NS; s++) begin
      src_req = NS'(1) << (s - 1);
      settle();
      check($sformatf("R3 irq src %0d", s), 32'(ctx_irq),
            {30'b0, (s >= 4 && s <= 7), 1'b1});
      rd(a_clm(0), v); check($sformatf("R4 claim src %0d", s), v, 32'(s));
      settle();
      check($sformatf("R5 held off src %0d", s), 32'(ctx_irq), 0);
      src_req = '0;
      wr(a_clm(0), 32'(s));
      settle();
      rd(a_clm(0), v); check($sformatf("R6 idle after completion %0d", s), v, 0);
    end

    // R4 ordering and ties
    wr(a_prio(2), 2); wr(a_prio(3), 5); wr(a_prio(9), 5); wr(a_prio(20), 7);
    src_req = (NS'(1) << 1) | (NS'(1) << 2) | (NS'(1) << 8) | (NS'(1) << 19);
    settle();
    rd(a_clm(0), v); check("R4 highest priority", v, 20);
    rd(a_clm(0), v); check("R4 tie lowest ID", v, 3);
    rd(a_clm(0), v); check("R4 tie second", v, 9);
    rd(a_clm(0), v); check("R4 lowest priority", v, 2);
    rd(a_clm(0), v); check("R7 all in service", v, 0);
    settle();
    check("R5 levels held off", 32'(ctx_irq), 0);
    wr(a_clm(0), 3);
    settle();
    rd(a_clm(0), v); check("R6 relatch after completion", v, 3);

    // R5 exclusivity between contexts
    wr(a_prio(5), 4);
    src_req[4] = 1'b1;
    settle();
    src_req[4] = 1'b0;
    check("R3 both contexts see source 5", 32'(ctx_irq), 32'h3);
    rd(a_clm(1), v); check("R5 ctx1 claims 5", v, 5);
    rd(a_clm(0), v); check("R5 ctx0 cannot claim 5", v, 0);
    wr(a_clm(1), 5);

    // R3 strict threshold
    wr(a_prio(6), 3);
    wr(a_thr(1), 3);
    src_req[5] = 1'b1;
    settle();
    check("R3 priority equal to threshold", 32'(ctx_irq[1]), 0);
    wr(a_thr(1), 2);
    settle();
    check("R3 priority above threshold", 32'(ctx_irq[1]), 1);
    rd(a_clm(1), v); check("R4 ctx1 claims 6", v, 6);
    src_req[5] = 1'b0;
    wr(a_clm(1), 6);

    // R10 priority zero
    wr(a_prio(7), 0);
    wr(a_thr(1), 0);
    src_req[6] = 1'b1;
    settle();
    check("R10 priority 0 no irq", 32'(ctx_irq[1]), 0);
    rd(a_clm(1), v); check("R10 priority 0 not claimed", v, 0);

    // R6 completion of an idle source changes nothing
    wr(a_clm(1), 7);
    wr(a_clm(1), 0);
    wr(a_clm(1), 40);
    src_req[6] = 1'b0;
    wr(a_prio(7), 1);
    settle();
    check("R6 stray completion kept pending", 32'(ctx_irq[1]), 1);
    rd(a_clm(1), v); check("R6 pending survived stray completion", v, 7);

    // R9 reset in the middle of activity
    src_req = '0;
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R9 irq cleared", 32'(ctx_irq), 0);
    rd(a_prio(20), v); check("R9 priority cleared", v, 0);
    rd(a_en(0, 0), v); check("R9 enables cleared", v, 0);
    rd(a_thr(1), v);   check("R9 threshold cleared", v, 0);
    wr(a_prio(9), 1); wr(a_en(0, 0), 32'h200);
    settle();
    rd(a_clm(0), v); check("R9 pending cleared", v, 0);

    summary();
  end
endmodule